// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-style core. Each cycle it takes the working-register operand `opa`, a second operand `opb` (a file register or a literal), an incoming carry and an operation code. From these it forms a byte result and next values for the zero, carry and digit-carry flags. It also produces a three-bit mask that names the flags the operation is allowed to change. The result and the next-flag values are combinational.

A small status register holds the three flags. When `exec_en` is high on a clock edge, the register loads only the flags that the mask names and keeps the others. Choosing where the result goes and decoding instructions are left to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: With op code 0 (add), `result` is (opa+opb) mod 256. `c_next` is the carry out of bit 7 and `dc_next` is the carry out of bit 3 into bit 4. `flag_mask` is 3'b111.
- R2: With op code 1 (subtract), `result` is (opb-opa) mod 256, formed as opb plus the two's complement of opa. `c_next` is 1 exactly when opb >= opa (no borrow). `dc_next` is 1 exactly when opb[3:0] >= opa[3:0]. `flag_mask` is 3'b111.
- R3: The logic operations are op 2 (opa AND opb), op 3 (opa OR opb), op 4 (opa XOR opb) and op 5 (bitwise complement of opb). Each gives that byte with `flag_mask` 3'b100 (zero flag only).
- R4: Op 6 gives (opb+1) mod 256 and op 7 gives (opb-1) mod 256. Both have `flag_mask` 3'b100.
- R5: Op 8 rotates opb left through the carry: each bit moves one place toward bit 7, `carry_in` enters bit 0, and `c_next` is the old bit 7. Op 9 is the mirror: `carry_in` enters bit 7 and `c_next` is the old bit 0. Both have `flag_mask` 3'b001.
- R6: Op 10 exchanges opb[7:4] with opb[3:0]. `flag_mask` is 3'b000.
- R7: Op 11 passes opb unchanged with `flag_mask` 3'b100. Op 15 passes opa unchanged with `flag_mask` 3'b000.
- R8: Op 12 (clear) gives 8'h00 with `flag_mask` 3'b100 and `z_next` 1, whatever the operand values.
- R9: Op 13 sets bit `bit_sel` (0 to 7) of opb and op 14 clears it. All other bits of opb pass unchanged, and `flag_mask` is 3'b000.
- R10: For every operation, `z_next` is 1 exactly when `result` is 8'h00.
- R11: `flag_mask` uses bit 2 for Z, bit 1 for DC and bit 0 for C. The flags `z_q`, `dc_q` and `c_q` reset to 0. On a rising edge with `exec_en` high, each flag whose mask bit is set loads its next value and each other flag keeps its value. With `exec_en` low, all three flags hold. The new flag values are visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the status flags |
| exec_en | input | 1 | Commit the masked flags on this edge |
| op_code | input | 4 | Operation select |
| opa | input | 8 | Working-register operand |
| opb | input | 8 | File-register or literal operand |
| carry_in | input | 1 | Carry used by the rotates |
| bit_sel | input | 3 | Bit position for set and clear |
| result | output | 8 | Operation result |
| z_next | output | 1 | Next zero flag |
| c_next | output | 1 | Next carry flag |
| dc_next | output | 1 | Next digit-carry flag |
| flag_mask | output | 3 | Flags this operation updates |
| z_q | output | 1 | Registered zero flag |
| c_q | output | 1 | Registered carry flag |
| dc_q | output | 1 | Registered digit-carry flag |

## Verification
`result`, the next-flag values and `flag_mask` are due in the same cycle as the inputs. The bench changes the inputs just after a rising edge and compares these outputs at the following falling edge. The registered flags change only at the rising edge that follows an `exec_en` cycle. The reference model therefore commits its own masked flags at that edge and compares them at the next falling edge, so a missing, late or unmasked load is seen one step later. Cycles with `exec_en` low are mixed in so that holding the flags is checked too.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_IOR  = 4'd3,
    OP_XOR  = 4'd4,
    OP_COM  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_SWP  = 4'd10,
    OP_PASB = 4'd11,
    OP_CLR  = 4'd12,
    OP_BSET = 4'd13,
    OP_BCLR = 4'd14,
    OP_PASA = 4'd15
  } alu_op_e;

  // flag vector layout: [2]=Z, [1]=DC, [0]=C
  localparam int FLAG_N  = 3;
  localparam int FI_C    = 0;
  localparam int FI_DC   = 1;
  localparam int FI_Z    = 2;

  localparam logic [FLAG_N-1:0] FM_NONE = 3'b000;
  localparam logic [FLAG_N-1:0] FM_C    = 3'b001;
  localparam logic [FLAG_N-1:0] FM_Z    = 3'b100;
  localparam logic [FLAG_N-1:0] FM_ALL  = 3'b111;

  function automatic logic [FLAG_N-1:0] mask_of(alu_op_e op);
    case (op)
      OP_ADD, OP_SUB:                 mask_of = FM_ALL;
      OP_AND, OP_IOR, OP_XOR, OP_COM,
      OP_INC, OP_DEC, OP_PASB, OP_CLR: mask_of = FM_Z;
      OP_RLC, OP_RRC:                 mask_of = FM_C;
      default:                        mask_of = FM_NONE;
    endcase
  endfunction

  function automatic logic is_arith(alu_op_e op);
    is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic          carry,
  output logic          half_carry
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] x_w, y_w;
  logic          ci_w;
  logic [DW:0]   full_w;
  logic [HALF:0] low_w;

  function automatic logic [DW:0] add_full(logic [DW-1:0] p, logic [DW-1:0] q, logic ci);
    add_full = {1'b0, p} + {1'b0, q} + {{DW{1'b0}}, ci};
  endfunction

  function automatic logic [HALF:0] add_low(logic [HALF-1:0] p, logic [HALF-1:0] q, logic ci);
    add_low = {1'b0, p} + {1'b0, q} + {{HALF{1'b0}}, ci};
  endfunction

  // every arithmetic op is one adder pass: subtract = b + ~a + 1
  always_comb begin
    case (op)
      OP_SUB: begin x_w = b; y_w = ~a;         ci_w = 1'b1; end
      OP_INC: begin x_w = b; y_w = '0;         ci_w = 1'b1; end
      OP_DEC: begin x_w = b; y_w = {DW{1'b1}}; ci_w = 1'b0; end
      default: begin x_w = a; y_w = b;         ci_w = 1'b0; end
    endcase
  end

  assign full_w     = add_full(x_w, y_w, ci_w);
  assign low_w      = add_low(x_w[HALF-1:0], y_w[HALF-1:0], ci_w);
  assign sum        = full_w[DW-1:0];
  assign carry      = full_w[DW];
  assign half_carry = low_w[HALF];

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic [BW-1:0] bsel,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] sel_oh;

  for (genvar i = 0; i < DW; i++) begin : g_dec
    assign sel_oh[i] = (bsel == BW'(i));
  end

  function automatic logic [DW-1:0] rot_l(logic [DW-1:0] v, logic ci);
    rot_l = {v[DW-2:0], ci};
  endfunction

  function automatic logic [DW-1:0] rot_r(logic [DW-1:0] v, logic ci);
    rot_r = {ci, v[DW-1:1]};
  endfunction

  function automatic logic [DW-1:0] swap_h(logic [DW-1:0] v);
    swap_h = {v[HALF-1:0], v[DW-1:HALF]};
  endfunction

  always_comb begin
    cout = cin;
    case (op)
      OP_AND:  res = a & b;
      OP_IOR:  res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~b;
      OP_RLC:  begin res = rot_l(b, cin); cout = b[DW-1]; end
      OP_RRC:  begin res = rot_r(b, cin); cout = b[0];    end
      OP_SWP:  res = swap_h(b);
      OP_PASB: res = b;
      OP_PASA: res = a;
      OP_BSET: res = b | sel_oh;
      OP_BCLR: res = b & ~sel_oh;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [FLAG_N-1:0] mask,
  input  logic [FLAG_N-1:0] flags_d,
  output logic [FLAG_N-1:0] flags_q
);

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flags_q[i] <= 1'b0;
      else if (exec_en && mask[i]) flags_q[i] <= flags_d[i];
    end
  end

  // R11: idle cycles leave every flag alone
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> flags_q == $past(flags_q));

  // R11: unmasked flags hold through an executed operation
  a_r11_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && mask == FM_NONE) |=> flags_q == $past(flags_q));

  // R11: a full-mask commit takes every next value
  a_r11_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && mask == FM_ALL) |=> flags_q == $past(flags_d));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [3:0]        op_code,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic              carry_in,
  input  logic [BW-1:0]     bit_sel,
  output logic [DW-1:0]     result,
  output logic              z_next,
  output logic              c_next,
  output logic              dc_next,
  output logic [FLAG_N-1:0] flag_mask,
  output logic              z_q,
  output logic              c_q,
  output logic              dc_q
);

  alu_op_e           op_e;
  logic [DW-1:0]     arith_res, bit_res;
  logic              arith_c, arith_dc, bit_c;
  logic              use_arith;
  logic [FLAG_N-1:0] flags_d, flags_q;

  assign op_e      = alu_op_e'(op_code);
  assign use_arith = is_arith(op_e);

  alu8_arith #(.DW(DW)) u_arith (
    .op(op_e), .a(opa), .b(opb),
    .sum(arith_res), .carry(arith_c), .half_carry(arith_dc)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op(op_e), .a(opa), .b(opb), .cin(carry_in), .bsel(bit_sel),
    .res(bit_res), .cout(bit_c)
  );

  assign result    = use_arith ? arith_res : bit_res;
  assign z_next    = (result == '0);
  assign c_next    = use_arith ? arith_c : bit_c;
  assign dc_next   = use_arith ? arith_dc : 1'b0;
  assign flag_mask = mask_of(op_e);

  assign flags_d[FI_Z]  = z_next;
  assign flags_d[FI_DC] = dc_next;
  assign flags_d[FI_C]  = c_next;

  alu8_status u_status (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en),
    .mask(flag_mask), .flags_d(flags_d), .flags_q(flags_q)
  );

  assign z_q  = flags_q[FI_Z];
  assign dc_q = flags_q[FI_DC];
  assign c_q  = flags_q[FI_C];

  // R2: carry after subtract means no borrow
  a_r2_sub_noborrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_SUB) |-> (c_next == (opb >= opa)));

  // R5: rotate left feeds the carry into bit 0 and bit 7 out
  a_r5_rotl_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_RLC) |-> (c_next == opb[DW-1] && result[0] == carry_in));

  // R9: bit set touches at most one bit and leaves it high
  a_r9_bit_set_single: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_BSET) |-> ($countones(result ^ opb) <= 1 && result[bit_sel]));

  // R8: clear yields zero with the zero flag pending
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_CLR) |-> (result == '0 && z_next && flag_mask == FM_Z));

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec_en;
  logic [3:0] op_code;
  logic [7:0] opa, opb;
  logic       carry_in;
  logic [2:0] bit_sel;
  logic [7:0] result;
  logic       z_next, c_next, dc_next, z_q, c_q, dc_q;
  logic [2:0] flag_mask;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int mz = 0, mc = 0, mdc = 0;

  always #2.5 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
    .opa(opa), .opb(opb), .carry_in(carry_in), .bit_sel(bit_sel),
    .result(result), .z_next(z_next), .c_next(c_next), .dc_next(dc_next),
    .flag_mask(flag_mask), .z_q(z_q), .c_q(c_q), .dc_q(dc_q)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string req_of(int op);
    case (op)
      0: return "R1 add";
      1: return "R2 sub";
      2, 3, 4, 5: return "R3 logic";
      6, 7: return "R4 incdec";
      8, 9: return "R5 rotate";
      10: return "R6 swap";
      11, 15: return "R7 pass";
      12: return "R8 clear";
      default: return "R9 bitop";
    endcase
  endfunction

  task automatic ref_op(input int op, input int a, input int b, input int ci, input int sel,
                        output int res, output int c, output int dc, output int m);
    c = 0; dc = 0;
    case (op)
      0: begin res = (a + b) % 256; c = (a + b > 255); dc = ((a % 16) + (b % 16) > 15); m = 7; end
      1: begin res = (b - a + 256) % 256; c = (b >= a); dc = ((b % 16) >= (a % 16)); m = 7; end
      2: begin res = a & b; m = 4; end
      3: begin res = a | b; m = 4; end
      4: begin res = a ^ b; m = 4; end
      5: begin res = 255 - b; m = 4; end
      6: begin res = (b + 1) % 256; m = 4; end
      7: begin res = (b + 255) % 256; m = 4; end
      8: begin res = (b * 2) % 256 + ci; c = b / 128; m = 1; end
      9: begin res = b / 2 + ci * 128; c = b % 2; m = 1; end
      10: begin res = (b % 16) * 16 + b / 16; m = 0; end
      11: begin res = b; m = 4; end
      12: begin res = 0; m = 4; end
      13: begin res = b | (1 << sel); m = 0; end
      14: begin res = b & (255 - (1 << sel)); m = 0; end
      default: begin res = a; m = 0; end
    endcase
  endtask

  task automatic step(int op, int a, int b, int ci, int sel, int ex);
    int res, c, dc, m, z;
    string rq;
    op_code = op[3:0]; opa = a[7:0]; opb = b[7:0];
    carry_in = ci[0]; bit_sel = sel[2:0]; exec_en = ex[0];
    ref_op(op, a, b, ci, sel, res, c, dc, m);
    z = (res == 0);
    rq = req_of(op);
    @(negedge clk);
    chk({rq, " result"}, int'(result), res);
    chk({rq, " mask"}, int'(flag_mask), m);
    chk("R10 z_next", int'(z_next), z);
    if (m % 2 == 1) chk({rq, " c_next"}, int'(c_next), c);
    if (m == 7) chk({rq, " dc_next"}, int'(dc_next), dc);
    chk("R11 z_q", int'(z_q), mz);
    chk("R11 c_q", int'(c_q), mc);
    chk("R11 dc_q", int'(dc_q), mdc);
    if (ex != 0) begin
      if (m >= 4) mz = z;
      if ((m / 2) % 2 == 1) mdc = dc;
      if (m % 2 == 1) mc = c;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; op_code = 4'd0; opa = 8'd0; opb = 8'd0;
    carry_in = 1'b0; bit_sel = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset z_q", int'(z_q), 0);
    chk("R11 reset c_q", int'(c_q), 0);
    chk("R11 reset dc_q", int'(dc_q), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1 corners: wrap to zero with carry, low-nibble carry
    step(0, 8'h80, 8'h80, 0, 0, 1);
    step(0, 8'h0F, 8'h01, 0, 0, 1);
    step(0, 8'hFF, 8'h01, 1, 0, 1);
    // R2 corners: equal, borrow, nibble borrow
    step(1, 8'h33, 8'h33, 0, 0, 1);
    step(1, 8'h01, 8'h00, 0, 0, 1);
    step(1, 8'h01, 8'h10, 0, 0, 1);
    // R11: idle cycle must not commit (add would set C)
    step(0, 8'hFF, 8'hFF, 0, 0, 0);
    step(15, 8'h00, 8'h00, 0, 0, 1);
    // R5 rotates with both carry values
    step(8, 0, 8'h81, 0, 0, 1);
    step(9, 0, 8'h01, 1, 0, 1);
    step(8, 0, 8'h00, 0, 0, 1);
    // R6, R7, R8, R9 corners
    step(10, 0, 8'hA5, 0, 0, 1);
    step(11, 8'h12, 8'h00, 0, 0, 1);
    step(12, 8'hFF, 8'hFF, 1, 0, 1);
    step(13, 0, 8'h00, 0, 7, 1);
    step(14, 0, 8'hFF, 0, 0, 1);
    step(14, 0, 8'h01, 0, 0, 1);
    // R4 wrap corners
    step(6, 0, 8'hFF, 0, 0, 1);
    step(7, 0, 8'h00, 0, 0, 1);
    step(7, 0, 8'h01, 0, 0, 1);
    // R3 complement to zero
    step(5, 0, 8'hFF, 0, 0, 1);
    for (int k = 0; k < 800; k++)
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 3) != 0));
    step(15, 0, 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule